// File: doc/BRIEF.md
# Omega Multistage Request Network

This block carries N requests, with N a power of two, from N requester links to N memory ports. It uses log2(N) columns of two-by-two switches. A perfect-shuffle pattern joins each column to the one before it. Every request has a valid flag, a target port number and a payload. Each switch looks at one bit of the target number and sends the request up or down. After the last column, every request that survived sits on the port it named.

The path from the inputs to the outputs and the accept flags is pure combinational logic. A requester can therefore see in the same cycle whether its request got through. It retries later if it did not. When two requests at one switch want the same output, only one goes on. The other is dropped and its accept flag stays low. With `ROTATE` set to 0, the upper link of the contested switch always wins. With `ROTATE` set to 1, a single priority bit decides the winner. It starts at upper-wins after reset and flips after every clock edge at which any switch saw a clash.

Top module: `omega_net`

## Requirements
- R1: A lone valid request from any input i to any port d appears on port d: `out_valid[d]` is 1 and the port carries the request's payload. `accept[i]` is 1 in the same cycle, and every other output and accept bit is 0.
- R2: A full permutation with no clash is delivered entirely, with all N accept bits set. Identity, every cyclic shift (d = (i+c) mod N) and every bitwise complement pattern (d = i XOR c) are such permutations.
- R3: `accept[i]` is never 1 unless `req_valid[i]` is 1. With no valid input, every `out_valid` and `accept` bit is 0.
- R4: With `ROTATE` = 0, when two requests meet at a switch and want the same output, the one on the switch's upper link is forwarded. The other has `accept` low. The number of accept bits set always equals the number of `out_valid` bits set.
- R5: With `ROTATE` = 1, the priority flips after each clock edge at which any switch saw a clash, so the other contender wins next time. Edges without a clash leave the priority unchanged.
- R6: The data lines of a port whose `out_valid` is 0 read zero. The target and payload of inputs whose valid bit is 0 have no effect on any output.
- R7: While `rst_n` is low, and after it is released until the first clash, the upper contender wins.
- R8: Results follow the inputs within the same cycle: accept and output change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the priority bit |
| rst_n | input | 1 | Active-low reset of the priority bit |
| req_valid | input | N | Request present on each input link |
| req_dest | input | N*log2(N) | Target port of input i in bits [i*log2(N) +: log2(N)] |
| req_data | input | N*DW | Payload of input i in bits [i*DW +: DW] |
| accept | output | N | Input i reached its target this cycle |
| out_valid | output | N | A request is present on memory port p |
| out_data | output | N*DW | Payload on port p in bits [p*DW +: DW], zero when idle |

## Verification
Routing, accept flags and output data all appear in the same cycle as the stimulus. The bench therefore changes inputs on the falling edge and samples 5 ns later, before the next rising edge. The rotating priority is the only registered result. It changes on the rising edge that follows a cycle with a clash, so the bench checks its effect in the next half-cycle window. No other input changes between that edge and the sample.

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N      = 8,
  parameter int DW     = 8,
  parameter bit ROTATE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             req_valid,
  input  logic [N*$clog2(N)-1:0]   req_dest,
  input  logic [N*DW-1:0]          req_data,
  output logic [N-1:0]             accept,
  output logic [N-1:0]             out_valid,
  output logic [N*DW-1:0]          out_data
);
  localparam int LOGN = $clog2(N);
  localparam int HALF = N / 2;

  logic            v [LOGN+1][N];
  logic [LOGN-1:0] d [LOGN+1][N];
  logic [LOGN-1:0] s [LOGN+1][N];
  logic [DW-1:0]   x [LOGN+1][N];
  logic [LOGN*HALF-1:0] clash;
  logic prio_q;

  for (genvar i = 0; i < N; i++) begin : g_in
    assign v[0][i] = req_valid[i];
    assign d[0][i] = req_dest[i*LOGN +: LOGN];
    assign s[0][i] = LOGN'(i);
    assign x[0][i] = req_data[i*DW +: DW];
  end

  for (genvar k = 0; k < LOGN; k++) begin : g_stage
    for (genvar j = 0; j < HALF; j++) begin : g_sw
      logic uv, lv, ub, lb, low_wins, ukeep, lkeep, up_to0, up_to1, lo_to0, lo_to1;
      assign uv = v[k][j];
      assign lv = v[k][j+HALF];
      assign ub = d[k][j][LOGN-1-k];
      assign lb = d[k][j+HALF][LOGN-1-k];
      assign clash[k*HALF+j] = uv && lv && (ub == lb);
      assign low_wins = ROTATE && prio_q;
      assign ukeep = uv && !(clash[k*HALF+j] && low_wins);
      assign lkeep = lv && !(clash[k*HALF+j] && !low_wins);
      assign up_to0 = ukeep && !ub;
      assign up_to1 = ukeep && ub;
      assign lo_to0 = lkeep && !lb;
      assign lo_to1 = lkeep && lb;

      assign v[k+1][2*j]   = up_to0 || lo_to0;
      assign d[k+1][2*j]   = up_to0 ? d[k][j] : d[k][j+HALF];
      assign s[k+1][2*j]   = up_to0 ? s[k][j] : s[k][j+HALF];
      assign x[k+1][2*j]   = up_to0 ? x[k][j] : x[k][j+HALF];
      assign v[k+1][2*j+1] = up_to1 || lo_to1;
      assign d[k+1][2*j+1] = up_to1 ? d[k][j] : d[k][j+HALF];
      assign s[k+1][2*j+1] = up_to1 ? s[k][j] : s[k][j+HALF];
      assign x[k+1][2*j+1] = up_to1 ? x[k][j] : x[k][j+HALF];
    end
  end

  for (genvar p = 0; p < N; p++) begin : g_out
    assign out_valid[p] = v[LOGN][p];
    assign out_data[p*DW +: DW] = v[LOGN][p] ? x[LOGN][p] : '0;
  end

  always_comb begin
    accept = '0;
    for (int p = 0; p < N; p++)
      if (v[LOGN][p]) accept[s[LOGN][p]] = 1'b1;
  end

  if (ROTATE) begin : g_rot
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      prio_q <= 1'b0;
      else if (|clash) prio_q <= ~prio_q;

    p_prio_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      |clash |=> (prio_q != $past(prio_q)));
    p_prio_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(|clash) |=> $stable(prio_q));
  end else begin : g_fix
    assign prio_q = 1'b0;
  end

  p_accept_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept & ~req_valid) == '0);
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (out_valid == '0 && accept == '0));
  p_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req_valid) == 1) |-> ($countones(accept) == 1 && $countones(out_valid) == 1));
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(accept) == $countones(out_valid));
endmodule

// File: tb/omega_net_test.sv
module omega_net_test;
  localparam int N = 8;
  localparam int LOGN = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_valid;
  logic [N*LOGN-1:0] req_dest;
  logic [N*DW-1:0] req_data;
  logic [N-1:0] acc_r, ov_r, acc_f, ov_f;
  logic [N*DW-1:0] od_r, od_f;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  omega_net #(.N(N), .DW(DW), .ROTATE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_data(req_data), .accept(acc_r), .out_valid(ov_r), .out_data(od_r));

  omega_net #(.N(N), .DW(DW), .ROTATE(1'b0)) uut_fix (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_data(req_data), .accept(acc_f), .out_valid(ov_f), .out_data(od_f));

  // {kind (0 add, 1 xor), constant, valid mask}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'hFF}, {1'b0, 3'd1, 8'hFF}, {1'b0, 3'd3, 8'hFF},
    {1'b0, 3'd7, 8'hFF}, {1'b1, 3'd7, 8'hFF}, {1'b1, 3'd5, 8'hFF},
    {1'b1, 3'd2, 8'hFF}, {1'b0, 3'd2, 8'h01}, {1'b1, 3'd3, 8'h20},
    {1'b0, 3'd5, 8'h80}, {1'b0, 3'd4, 8'h5A}, {1'b1, 3'd0, 8'h00}};

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives inputs; invalid links get junk target/payload (R6).
  task automatic drive(input logic [N-1:0] m, input logic [N*LOGN-1:0] dst);
    req_valid = m;
    req_dest = dst;
    for (int i = 0; i < N; i++)
      req_data[i*DW +: DW] = m[i] ? DW'(8'h30 + i) : 8'hEE;
  endtask

  task automatic expect_free(input string tag, input logic [N-1:0] m, input logic [N*LOGN-1:0] dst);
    logic [N-1:0] ev;
    logic [N*DW-1:0] ed;
    ev = '0;
    ed = '0;
    for (int i = 0; i < N; i++)
      if (m[i]) begin
        ev[dst[i*LOGN +: LOGN]] = 1'b1;
        ed[dst[i*LOGN +: LOGN]*DW +: DW] = DW'(8'h30 + i);
      end
    chk({tag, " rot"}, {od_r, ov_r, acc_r}, {ed, ev, m});
    chk({tag, " fix"}, {od_f, ov_f, acc_f}, {ed, ev, m});
  endtask

  task automatic conflict(input logic [N-1:0] exp_acc_r, input string tag);
    logic [N*LOGN-1:0] dst;
    dst = '0;
    dst[0 +: LOGN] = 3'd5;
    dst[LOGN +: LOGN] = 3'd5;
    drive(8'h03, dst);
    #5;
    chk({tag, " rot accept"}, acc_r, exp_acc_r);
    chk({tag, " rot port5"}, od_r[5*DW +: DW], exp_acc_r[0] ? 8'h30 : 8'h31);
    chk("R4 fixed upper wins", {od_f[5*DW +: DW], ov_f, acc_f}, {8'h30, 8'h20, 8'h01});
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N*LOGN-1:0] dst;
    req_valid = '0;
    req_dest = '0;
    req_data = '0;
    repeat (2) @(negedge clk);
    chk("R3 reset idle", {ov_r, acc_r, od_r, ov_f, acc_f}, '0);
    @(negedge clk);
    conflict(8'h01, "R7 in reset");
    @(negedge clk);
    conflict(8'h01, "R7 in reset hold");
    @(negedge clk);
    drive('0, '0);
    rst_n = 1'b1;

    for (int t = 0; t < NV; t++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++)
        dst[i*LOGN +: LOGN] = VEC[t][11] ? (LOGN'(i) ^ VEC[t][10:8])
                                        : LOGN'(i + VEC[t][10:8]);
      for (int i = 0; i < N; i++)
        if (!VEC[t][i]) dst[i*LOGN +: LOGN] = LOGN'(i * 5 + 1);
      drive(VEC[t][7:0], dst);
      #5;
      expect_free(VEC[t][7:0] == 8'hFF ? "R2 permutation" : "R6 partial", VEC[t][7:0], dst);
    end

    for (int sidx = 0; sidx < N; sidx++)
      for (int di = 0; di < N; di++) begin
        @(negedge clk);
        dst = '0;
        for (int i = 0; i < N; i++) dst[i*LOGN +: LOGN] = LOGN'(7 - i);
        dst[sidx*LOGN +: LOGN] = LOGN'(di);
        drive(8'h01 << sidx, dst);
        #5;
        expect_free("R1 single", 8'h01 << sidx, dst);
      end

    // R8: same-cycle response after a mid-cycle change, no edge between.
    @(negedge clk);
    drive(8'h04, {8{3'd6}});
    #2;
    chk("R8 first", {ov_r, acc_r}, {8'h40, 8'h04});
    drive(8'h10, {8{3'd1}});
    #2;
    chk("R8 changed", {ov_r, acc_r}, {8'h02, 8'h10});

    @(negedge clk);
    conflict(8'h01, "R7 after release");
    @(negedge clk);
    conflict(8'h02, "R5 flipped");
    @(negedge clk);
    conflict(8'h01, "R5 flipped back");
    @(negedge clk);
    #5;
    drive('0, '0);
    repeat (3) @(negedge clk);
    chk("R3 idle outputs", {ov_r, acc_r, ov_f, acc_f}, '0);
    conflict(8'h02, "R5 held over idle");

    @(negedge clk);
    drive('0, '0);
    #5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule